// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in an external memory. A request carries the virtual address and a read/write flag. The walker fetches a top-level entry from the table whose base sits in an address-space base input. It then fetches a leaf entry from the table that the top-level entry points to, and checks the leaf's control bits. It answers with either a physical address or a fault code.

On a successful access the walker can write the leaf entry back first. It does this when the entry's used bit, or for a write its modified bit, still needs setting. Software switches address spaces by loading a different value on the base input between walks.

The memory port reads synchronously with exactly one cycle of latency and writes in a single cycle. Virtual address fields are the top-level index in bits 31:22, the leaf index in bits 21:12 and the page offset in bits 11:0. Table entries are 32 bits:

| Entry bits | Meaning |
|---|---|
| 31:12 | frame number |
| 0 | present |
| 1 | writable |
| 2 | used |
| 3 | modified |
| 4 | copy-on-write |

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid`, `mem_rd_en` and `mem_wr_en` are all 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the walker returns to idle. Request inputs that change while the walker is busy have no effect on the response.
- R3: The first read is issued in the cycle after acceptance at `base + 4*vaddr[31:22]`. The leaf read is issued two cycles later at `{top_entry[31:12], 12'h000} + 4*vaddr[21:12]`. Each read returns its data one cycle after it is issued.
- R4: A top-level entry with bit 0 clear ends the walk with fault code 1 (not present). No leaf read is made, and the response comes three cycles after acceptance.
- R5: A leaf entry with bit 0 clear gives fault code 1. On any fault, `rsp_paddr` is 0 and no memory write occurs.
- R6: On success, the fault code is 0 and `rsp_paddr = {leaf[31:12], vaddr[11:0]}`.
- R7: A write to a present leaf with bit 4 (copy-on-write) set gives fault code 3. This fault wins over the write-protection check.
- R8: A write to a present leaf with bit 1 (writable) clear and bit 4 clear gives fault code 2. A read of such a page succeeds.
- R9: On success, if bit 2 is clear, or the access is a write and bit 3 is clear, the walker writes the leaf entry back to the leaf address with bit 2 set (and bit 3 for a write). The write happens the cycle before the response. When no bit changes, no write is made.
- R10: `rsp_valid` is a single-cycle pulse. It comes five cycles after acceptance without a write-back and six cycles after with one. `req_ready` returns to 1 in the following cycle.
- R11: The base input is sampled at acceptance. Changing it mid-walk does not affect the walk. A new base value selects a different set of tables for later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | translation request present |
| req_ready | output | 1 | walker idle and able to take a request |
| req_vaddr | input | 32 | virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| as_base | input | 32 | physical base of the top-level table for the current address space |
| mem_rd_en | output | 1 | memory read strobe |
| mem_wr_en | output | 1 | memory write strobe (entry update) |
| mem_addr | output | 32 | memory byte address for the read or write |
| mem_wdata | output | 32 | entry value to write |
| mem_rdata | input | 32 | read data, valid one cycle after the strobe |
| rsp_valid | output | 1 | response pulse |
| rsp_paddr | output | 32 | translated physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 write-protect, 3 copy-on-write |

## Verification
The bench targets several corner cases that a faulty design would get wrong:
- A missing top-level entry: a design that ignored it would go on to read a garbage leaf and hand back an address.
- A page that is both copy-on-write and read-only: swapped check priorities would show up as code 2 instead of 3.
- Pages whose used or modified bits are already set, and pages that fault: a design that always wrote back would show a stray write strobe and a response one cycle late.
- A walk during which the request inputs and the base are disturbed: a walker that failed to sample them at acceptance would read from the wrong table or mix offsets.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = (VA_W - OFF_W) / 2;
  localparam int FRM_W = VA_W - OFF_W;
  localparam int PAD_W = VA_W - IDX_W - 2;

  localparam int PB_PRESENT  = 0;
  localparam int PB_WRITABLE = 1;
  localparam int PB_USED     = 2;
  localparam int PB_MODIFIED = 3;
  localparam int PB_COW      = 4;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_WPROT  = 2'd2,
    FLT_COW    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_TOP, S_WT_TOP, S_RD_LEAF, S_WT_LEAF, S_UPDATE, S_RESP
  } walk_st_e;

  function automatic logic [VA_W-1:0] slot_addr(input logic [VA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + {{PAD_W{1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] frame_base(input logic [VA_W-1:0] pte);
    return {pte[VA_W-1 -: FRM_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] join_paddr(input logic [VA_W-1:0] pte,
                                                 input logic [VA_W-1:0] va);
    return {pte[VA_W-1 -: FRM_W], va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen
  import pt_walker_pkg::*;
(
  input  walk_st_e         st,
  input  logic [VA_W-1:0]  top_base,
  input  logic [VA_W-1:0]  leaf_base,
  input  logic [VA_W-1:0]  vaddr,
  output logic [VA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx_top, idx_leaf;
  assign idx_top  = vaddr[VA_W-1 -: IDX_W];
  assign idx_leaf = vaddr[OFF_W +: IDX_W];

  always_comb begin
    if (st == S_RD_TOP) addr = slot_addr(top_base, idx_top);
    else                addr = slot_addr(leaf_base, idx_leaf);
  end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
(
  input  logic [VA_W-1:0] pte,
  input  logic            is_write,
  output fault_e          fault,
  output logic            need_update,
  output logic [VA_W-1:0] pte_next
);
  always_comb begin
    if (!pte[PB_PRESENT])                  fault = FLT_ABSENT;
    else if (is_write && pte[PB_COW])      fault = FLT_COW;
    else if (is_write && !pte[PB_WRITABLE]) fault = FLT_WPROT;
    else                                   fault = FLT_NONE;
  end

  always_comb begin
    pte_next = pte;
    pte_next[PB_USED] = 1'b1;
    if (is_write) pte_next[PB_MODIFIED] = 1'b1;
  end

  assign need_update = (fault == FLT_NONE) && (pte_next != pte);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  input  logic [VA_W-1:0] as_base,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault
);
  walk_st_e        st;
  logic [VA_W-1:0] vaddr_q, base_q, leaf_base_q, paddr_q, upd_q;
  logic            write_q;
  fault_e          fault_q;

  fault_e          leaf_fault;
  logic            leaf_upd;
  logic [VA_W-1:0] leaf_next;

  // named events for the checker
  logic accept, top_miss, leaf_seen;
  assign accept    = req_valid && req_ready;
  assign top_miss  = (st == S_WT_TOP) && !mem_rdata[PB_PRESENT];
  assign leaf_seen = (st == S_WT_LEAF);

  pt_addr_gen u_agen (
    .st(st), .top_base(base_q), .leaf_base(leaf_base_q),
    .vaddr(vaddr_q), .addr(mem_addr)
  );

  pt_entry_check u_chk (
    .pte(mem_rdata), .is_write(write_q), .fault(leaf_fault),
    .need_update(leaf_upd), .pte_next(leaf_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      vaddr_q     <= '0;
      base_q      <= '0;
      leaf_base_q <= '0;
      paddr_q     <= '0;
      upd_q       <= '0;
      write_q     <= 1'b0;
      fault_q     <= FLT_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          vaddr_q <= req_vaddr;
          write_q <= req_write;
          base_q  <= as_base;
          st      <= S_RD_TOP;
        end
        S_RD_TOP: st <= S_WT_TOP;
        S_WT_TOP: begin
          if (top_miss) begin
            fault_q <= FLT_ABSENT;
            paddr_q <= '0;
            st      <= S_RESP;
          end else begin
            leaf_base_q <= frame_base(mem_rdata);
            st          <= S_RD_LEAF;
          end
        end
        S_RD_LEAF: st <= S_WT_LEAF;
        S_WT_LEAF: begin
          fault_q <= leaf_fault;
          upd_q   <= leaf_next;
          if (leaf_fault != FLT_NONE) begin
            paddr_q <= '0;
            st      <= S_RESP;
          end else begin
            paddr_q <= join_paddr(mem_rdata, vaddr_q);
            st      <= leaf_upd ? S_UPDATE : S_RESP;
          end
        end
        S_UPDATE: st <= S_RESP;
        S_RESP:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_rd_en = (st == S_RD_TOP) || (st == S_RD_LEAF);
  assign mem_wr_en = (st == S_UPDATE);
  assign mem_wdata = upd_q;
  assign rsp_valid = (st == S_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
endmodule

// File: rtl/pt_walker_sva.sv
module pt_walker_sva
  import pt_walker_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            accept,
  input logic            top_miss,
  input logic            leaf_seen,
  input logic            req_ready,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic [VA_W-1:0] mem_wdata,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_read_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_top_miss_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    top_miss |=> (rsp_valid && rsp_fault == 2'd1));

  assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  assert_update_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> rsp_valid);

  assert_update_sets_used_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[PB_USED]);

  assert_update_after_leaf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(leaf_seen));

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

bind pt_walker pt_walker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .accept(accept), .top_miss(top_miss),
  .leaf_seen(leaf_seen), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] as_base = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  bit [31:0]   mem [0:4095];
  logic        tb_we = 1'b0;
  logic [31:0] tb_wa = '0, tb_wd = '0;

  always #2 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .as_base(as_base),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  // behavioural memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[13:2]];
    if (mem_wr_en) mem[mem_addr[13:2]] <= mem_wdata;
    if (tb_we)     mem[tb_wa[13:2]] <= tb_wd;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected under 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic logic [31:0] va(input int i1, input int i2, input int off);
    return {i1[9:0], i2[9:0], off[11:0]};
  endfunction

  // reference walk: compare every cycle from acceptance to response
  task automatic walk(input logic [31:0] v, input logic wr, input bit disturb, input string tag);
    logic [31:0] base, top_a, top_e, leaf_a, leaf_e, new_e, exp_pa;
    logic [1:0]  exp_f;
    bit          miss, upd;
    int          rsp_k;
    base   = as_base;
    top_a  = base + {20'd0, v[31:22], 2'b00};
    top_e  = mem[top_a[13:2]];
    miss   = !top_e[0];
    leaf_a = {top_e[31:12], 12'h000} + {20'd0, v[21:12], 2'b00};
    leaf_e = mem[leaf_a[13:2]];
    new_e  = leaf_e | 32'h4 | (wr ? 32'h8 : 32'h0);
    upd    = 0;
    exp_pa = '0;
    if (miss || !leaf_e[0])      exp_f = 2'd1;
    else if (wr && leaf_e[4])    exp_f = 2'd3;
    else if (wr && !leaf_e[1])   exp_f = 2'd2;
    else begin
      exp_f  = 2'd0;
      exp_pa = {leaf_e[31:12], v[11:0]};
      upd    = (new_e != leaf_e);
    end
    rsp_k = miss ? 2 : (upd ? 5 : 4);

    @(negedge clk);
    check("R2 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_vaddr = v; req_write = wr;
    for (int k = 0; k <= rsp_k; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (disturb) begin
          req_vaddr = ~v; req_write = ~wr; as_base = 32'h0000_3000;
        end else req_valid = 1'b0;
      end
      if (k == rsp_k) req_valid = 1'b0;
      check("R2 busy", {31'd0, req_ready}, 32'd0);
      check("R10 response timing", {31'd0, rsp_valid}, {31'd0, k == rsp_k});
      check("R3/R4 read strobe", {31'd0, mem_rd_en}, {31'd0, (k == 0) || (k == 2 && !miss)});
      if (k == 0) check("R3 top address", mem_addr, top_a);
      if (k == 2 && !miss) check("R3 leaf address", mem_addr, leaf_a);
      check("R9 update strobe", {31'd0, mem_wr_en}, {31'd0, upd && k == 4});
      if (upd && k == 4) begin
        check("R9 update address", mem_addr, leaf_a);
        check("R9 update data", mem_wdata, new_e);
      end
      if (k == rsp_k) begin
        check({tag, " fault"}, {30'd0, rsp_fault}, {30'd0, exp_f});
        check({tag, " paddr"}, rsp_paddr, exp_pa);
      end
    end
    as_base = base;
    @(negedge clk);
    check("R10 idle again", {31'd0, req_ready}, 32'd1);
    check("R10 pulse ends", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, req_ready}, 32'd1);
    check("R1 no response", {31'd0, rsp_valid}, 32'd0);
    check("R1 no strobes", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    // top table at 0x1000, leaf tables at 0x2000 and 0x3000
    poke(32'h1004, 32'h0000_2001);
    poke(32'h2000, 32'hABCDE_003);  // writable, used clear
    poke(32'h2004, 32'h12345_00F);  // all set
    poke(32'h2008, 32'h22222_007);  // modified clear
    poke(32'h200C, 32'h33333_001);  // read-only
    poke(32'h2010, 32'h44444_017);  // writable + cow
    poke(32'h2014, 32'h55555_015);  // read-only + cow
    poke(32'h2018, 32'h66666_000);  // absent
    poke(32'h0004, 32'h0000_3001);  // second address space
    poke(32'h3000, 32'h77777_007);
    rst_n = 1'b1;
    as_base = 32'h1000;

    walk(va(1, 0, 12'h123), 1'b0, 0, "R6 read with used update");  // R9 used bit
    walk(va(1, 0, 12'h456), 1'b0, 0, "R9 no update once used");
    walk(va(1, 1, 12'hFFF), 1'b1, 0, "R6 write all bits set");
    walk(va(1, 2, 12'h000), 1'b1, 0, "R9 write sets modified");
    walk(va(1, 3, 12'h010), 1'b1, 0, "R8 write to read-only");
    walk(va(1, 3, 12'h010), 1'b0, 0, "R8 read of read-only");
    walk(va(1, 4, 12'h020), 1'b1, 0, "R7 write to cow");
    walk(va(1, 5, 12'h030), 1'b1, 0, "R7 cow over read-only");
    walk(va(1, 4, 12'h040), 1'b0, 0, "R7 read of cow");
    walk(va(1, 6, 12'h050), 1'b0, 0, "R5 leaf absent");
    walk(va(2, 0, 12'h060), 1'b1, 0, "R4 top absent");
    walk(va(1, 1, 12'hABC), 1'b0, 1, "R11 disturbed walk");
    as_base = 32'h0000;
    walk(va(1, 0, 12'h777), 1'b1, 0, "R11 switched space");
    as_base = 32'h1000;
    walk(va(1, 2, 12'h321), 1'b1, 0, "R9 second write no update");
    summary();
    $finish;
  end
endmodule